// File: doc/BRIEF.md
# Context Save Completion Checker

This block watches a hardware context-save operation after it has been launched and decides whether it finished cleanly. It does not drive the engine. It receives a start pulse, a free-running one-millisecond tick and the engine's sampled status signals. It then works through four checks in a fixed order:

- the operation-done flag,
- the engine's idle status,
- the bus write queue having drained the writes of both engines,
- a clean error word.

Each waiting check looks at its input only on tick cycles. Each check has its own budget of one hundred samples. A check begins only after the one before it has passed.

The first failure ends the sequence and produces a coded reason. If all four checks pass, a pass result is produced. The result appears on a one-cycle valid strobe, and the checker then returns to idle, ready for the next start. The block never retries on its own, and a start pulse that arrives while a sequence is running has no effect.

Top module: `ctx_save_checker`

## Requirements
- R1: After reset the checker is idle: `busy` and `resultValid` are low.
- R2: A `startPulse` seen while idle starts the sequence, and `busy` is high from the next cycle until the result is given.
- R3: The first check passes on the first `msTick` cycle on which `doneFlag` is 1. Status inputs are sampled only on `msTick` cycles, and their values on other cycles have no effect.
- R4: A waiting check whose condition is false on 100 consecutive tick samples fails on that 100th sample. The failure codes are 1 (done flag never set), 2 (engine never idle) and 3 (write queue never drained). A condition first met on the 100th sample still passes.
- R5: The second check passes on a tick sample where `engineStatus` equals zero.
- R6: The third check passes on a tick sample where bits 13 and 14 of `wrQueueBits` are both 0. The other bits of that word have no effect.
- R7: After the third check passes, `errStatus` is examined on the next cycle without waiting for a tick. A value of zero gives code 0 (pass), and any other value gives code 4.
- R8: The checks run strictly in order. Each check starts with a fresh 100-sample budget on the tick after the previous check passed. A failure ends the sequence, so the number of ticks consumed is fixed by the first failing check.
- R9: Each sequence yields exactly one `resultValid` pulse, one cycle long, with `resultCode`. `resultPass` is high only with a valid code of 0.
- R10: A `startPulse` while `busy` is high is ignored, and the running sequence's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a checking sequence |
| msTick | input | 1 | One-cycle pulse per millisecond, sample enable |
| doneFlag | input | 1 | Operation-done interrupt flag |
| engineStatus | input | 32 | Engine status word, zero means idle |
| wrQueueBits | input | 32 | Bus write-queue master-ID bits |
| errStatus | input | 32 | Engine error status word |
| busy | output | 1 | Sequence in progress |
| resultValid | output | 1 | One-cycle strobe qualifying the result |
| resultCode | output | 3 | 0 pass, 1 done timeout, 2 idle timeout, 3 drain timeout, 4 error |
| resultPass | output | 1 | High with a valid pass result |

## Verification
The hardest situations to reach from the ports are the budget edges of the later checks. Examples are an idle check that passes on its hundredth sample after a slow done flag, or a drain timeout that comes only after two earlier checks have each used part of their time. These cases only show up if the budgets really are reset between checks.

The stimulus reaches them with per-check delays expressed in tick samples. The delays are drawn at random, with some of them placed at 99 and 100, and the inputs are switched exactly on the tick where each condition is due. Between ticks the inputs are filled with random values that contradict the scheduled ones, and extra start pulses are injected mid-run. For each sequence the bench checks both the code and the number of ticks consumed.

// File: rtl/ctxchk_pkg.sv
package ctxchk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_DONE,
    ST_WAIT_IDLE,
    ST_WAIT_DRAIN,
    ST_CHECK_ERR
  } phase_t;

  localparam logic [2:0] RES_PASS      = 3'd0;
  localparam logic [2:0] RES_DONE_TO   = 3'd1;
  localparam logic [2:0] RES_IDLE_TO   = 3'd2;
  localparam logic [2:0] RES_DRAIN_TO  = 3'd3;
  localparam logic [2:0] RES_ERR_FLAG  = 3'd4;

  // Control to datapath strobes
  typedef struct packed {
    logic       clrCnt;
    logic       incCnt;
    logic       setResult;
    logic [2:0] code;
  } ctrlStrobes_t;

  // Datapath to control condition flags
  typedef struct packed {
    logic doneOk;
    logic idleOk;
    logic drainOk;
    logic errOk;
    logic cntLast;
  } dpStatus_t;

endpackage

// File: rtl/ctxchk_datapath.sv
module ctxchk_datapath
  import ctxchk_pkg::*;
#(
  parameter int STATUS_W    = 32,
  parameter int QUEUE_W     = 32,
  parameter int ERR_W       = 32,
  parameter int TICK_LIMIT  = 100,
  parameter int DRAIN_BIT_A = 13,
  parameter int DRAIN_BIT_B = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                doneFlag,
  input  logic [STATUS_W-1:0] engineStatus,
  input  logic [QUEUE_W-1:0]  wrQueueBits,
  input  logic [ERR_W-1:0]    errStatus,
  input  ctrlStrobes_t        strobes,
  output dpStatus_t           status,
  output logic                resultValid,
  output logic [2:0]          resultCode,
  output logic                resultPass
);

  localparam int CNT_W = $clog2(TICK_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_LIMIT - 1);
  localparam logic [QUEUE_W-1:0] ONE_Q = {{(QUEUE_W-1){1'b0}}, 1'b1};
  localparam logic [QUEUE_W-1:0] DRAIN_MASK =
    (ONE_Q << DRAIN_BIT_A) | (ONE_Q << DRAIN_BIT_B);

  logic [CNT_W-1:0] sampleCnt;
  logic [2:0]       codeReg;
  logic             validReg;

  // Failed-sample counter of the check in progress
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (strobes.clrCnt) begin
      sampleCnt <= '0;
    end else if (strobes.incCnt) begin
      sampleCnt <= sampleCnt + CNT_W'(1);
    end
  end

  // Result register, valid for one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validReg <= 1'b0;
      codeReg  <= RES_PASS;
    end else begin
      validReg <= strobes.setResult;
      if (strobes.setResult) begin
        codeReg <= strobes.code;
      end
    end
  end

  always_comb begin
    status.doneOk  = doneFlag;
    status.idleOk  = (engineStatus == '0);
    status.drainOk = ((wrQueueBits & DRAIN_MASK) == '0);
    status.errOk   = (errStatus == '0);
    status.cntLast = (sampleCnt == CNT_LAST);
  end

  assign resultValid = validReg;
  assign resultCode  = codeReg;
  assign resultPass  = validReg && (codeReg == RES_PASS);

endmodule

// File: rtl/ctxchk_control.sv
module ctxchk_control
  import ctxchk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         msTick,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  // One waiting check: advance on a met sample, fail on the last miss
  function automatic void waitStep(input logic met, input phase_t nextPh,
                                   input logic [2:0] failCode,
                                   inout phase_t ph, inout ctrlStrobes_t st);
    if (met) begin
      ph = nextPh;
      st.clrCnt = 1'b1;
    end else if (status.cntLast) begin
      ph = ST_IDLE;
      st.setResult = 1'b1;
      st.code = failCode;
    end else begin
      st.incCnt = 1'b1;
    end
  endfunction

  always_comb begin
    phase_t       ph;
    ctrlStrobes_t st;
    ph = phase;
    st = '0;
    unique case (phase)
      ST_IDLE: begin
        if (startPulse) begin
          ph = ST_WAIT_DONE;
          st.clrCnt = 1'b1;
        end
      end
      ST_WAIT_DONE:
        if (msTick) waitStep(status.doneOk, ST_WAIT_IDLE, RES_DONE_TO, ph, st);
      ST_WAIT_IDLE:
        if (msTick) waitStep(status.idleOk, ST_WAIT_DRAIN, RES_IDLE_TO, ph, st);
      ST_WAIT_DRAIN:
        if (msTick) waitStep(status.drainOk, ST_CHECK_ERR, RES_DRAIN_TO, ph, st);
      ST_CHECK_ERR: begin
        ph = ST_IDLE;
        st.setResult = 1'b1;
        st.code = status.errOk ? RES_PASS : RES_ERR_FLAG;
      end
      default: ph = ST_IDLE;
    endcase
    phaseNext = ph;
    strobes   = st;
  end

  assign busy = (phase != ST_IDLE);

endmodule

// File: rtl/ctx_save_checker.sv
module ctx_save_checker
  import ctxchk_pkg::*;
#(
  parameter int STATUS_W    = 32,
  parameter int QUEUE_W     = 32,
  parameter int ERR_W       = 32,
  parameter int TICK_LIMIT  = 100,
  parameter int DRAIN_BIT_A = 13,
  parameter int DRAIN_BIT_B = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic                msTick,
  input  logic                doneFlag,
  input  logic [STATUS_W-1:0] engineStatus,
  input  logic [QUEUE_W-1:0]  wrQueueBits,
  input  logic [ERR_W-1:0]    errStatus,
  output logic                busy,
  output logic                resultValid,
  output logic [2:0]          resultCode,
  output logic                resultPass
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  ctxchk_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .msTick     (msTick),
    .status     (status),
    .strobes    (strobes),
    .busy       (busy)
  );

  ctxchk_datapath #(
    .STATUS_W    (STATUS_W),
    .QUEUE_W     (QUEUE_W),
    .ERR_W       (ERR_W),
    .TICK_LIMIT  (TICK_LIMIT),
    .DRAIN_BIT_A (DRAIN_BIT_A),
    .DRAIN_BIT_B (DRAIN_BIT_B)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .doneFlag     (doneFlag),
    .engineStatus (engineStatus),
    .wrQueueBits  (wrQueueBits),
    .errStatus    (errStatus),
    .strobes      (strobes),
    .status       (status),
    .resultValid  (resultValid),
    .resultCode   (resultCode),
    .resultPass   (resultPass)
  );

endmodule

// File: rtl/ctx_save_checker_props.sv
module ctx_save_checker_props (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       msTick,
  input logic       busy,
  input logic       resultValid,
  input logic [2:0] resultCode,
  input logic       resultPass
);

  // R1: reset clears the result strobe and busy
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> !resultValid && !busy);

  // R2: a start while idle makes the checker busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !busy |=> busy);

  // R4: timeout codes only arise from a tick sample
  p_timeout_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && (resultCode inside {3'd1, 3'd2, 3'd3}) |-> $past(msTick));

  // R7: code range is bounded
  p_code_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> resultCode <= 3'd4);

  // R9: the strobe lasts one cycle and follows a busy sequence
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_valid_after_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(busy));
  p_pass_qualified_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultPass |-> resultValid && resultCode == 3'd0);

  // R10: a start while busy does not disturb the sequence
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && busy |=> busy || resultValid);

endmodule

bind ctx_save_checker ctx_save_checker_props u_props (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .msTick      (msTick),
  .busy        (busy),
  .resultValid (resultValid),
  .resultCode  (resultCode),
  .resultPass  (resultPass)
);

// File: tb/ctx_save_checker_test.sv
`timescale 1ns/1ps
module ctx_save_checker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        msTick = 1'b0;
  logic        doneFlag = 1'b0;
  logic [31:0] engineStatus = 32'h1;
  logic [31:0] wrQueueBits = 32'h6000;
  logic [31:0] errStatus = 32'h0;
  logic        busy, resultValid, resultPass;
  logic [2:0]  resultCode;

  int checks = 0;
  int fails = 0;
  int resCount = 0;
  int resTick = 0;
  int tickNum = 0;
  logic [2:0] resCode;
  logic resPassSeen;
  bit finished = 0;

  always #2 clk = ~clk;

  ctx_save_checker uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .msTick(msTick),
    .doneFlag(doneFlag), .engineStatus(engineStatus), .wrQueueBits(wrQueueBits),
    .errStatus(errStatus), .busy(busy), .resultValid(resultValid),
    .resultCode(resultCode), .resultPass(resultPass)
  );

  // Result monitor, sampling away from the rising edge
  always @(negedge clk) begin
    if (resultValid) begin
      resCount++;
      resTick = tickNum;
      resCode = resultCode;
      resPassSeen = resultPass;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(int d1, int d2, int d3, logic [31:0] e);
    if (d1 >= 100) return 1;
    if (d2 >= 100) return 2;
    if (d3 >= 100) return 3;
    return (e != 0) ? 4 : 0;
  endfunction

  function automatic int expTicks(int d1, int d2, int d3);
    if (d1 >= 100) return 100;
    if (d2 >= 100) return d1 + 1 + 100;
    if (d3 >= 100) return d1 + d2 + 2 + 100;
    return d1 + d2 + d3 + 3;
  endfunction

  function automatic string codeReq(int c);
    case (c)
      1: return "R4_done";
      2: return "R5_idle";
      3: return "R6_drain";
      default: return "R7_err";
    endcase
  endfunction

  // Drive inputs as the schedule requires for tick index t
  task automatic driveReal(int t, int d1, int d2, int d3);
    doneFlag = (t >= d1);
    engineStatus = (t >= d1 + 1 + d2) ? 32'h0 : ($urandom() | 32'h1);
    if (t >= d1 + d2 + 2 + d3)
      wrQueueBits = $urandom() & ~32'h6000;
    else
      wrQueueBits = $urandom() | (($urandom() % 3 + 1) << 13);
  endtask

  // Off-tick noise: contradicts the schedule
  task automatic driveNoise(int t, int d1, int d2, int d3);
    doneFlag = !(t >= d1);
    engineStatus = (t >= d1 + 1 + d2) ? ($urandom() | 32'h1) : 32'h0;
    if (t >= d1 + d2 + 2 + d3)
      wrQueueBits = $urandom() | 32'h2000;
    else
      wrQueueBits = $urandom() & ~32'h6000;
  endtask

  task automatic runSeq(int d1, int d2, int d3, logic [31:0] e, bit midStart);
    int ec, et;
    ec = expCode(d1, d2, d3, e);
    et = expTicks(d1, d2, d3);
    errStatus = e;
    resCount = 0;
    tickNum = 0;
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check("R2 busy after start", busy, 1);
    for (int t = 0; t < 400; t++) begin
      driveReal(t, d1, d2, d3);
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
      tickNum++;
      for (int g = 0; g < 3; g++) begin
        driveNoise(t, d1, d2, d3);
        if (midStart && t == 2 && g == 1) startPulse = 1'b1;
        @(negedge clk);
        startPulse = 1'b0;
      end
      if (resCount > 0) break;
    end
    repeat (6) @(negedge clk);
    check({codeReq(ec), " code"}, resCode, ec);
    check("R8 ticks consumed", resTick, et);
    check("R9 single result", resCount, 1);
    check("R9 pass flag", resPassSeen, (ec == 0));
    check("R2 idle after result", busy, 0);
    if (midStart) check("R10 mid start ignored", resCode, ec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid at reset", resultValid, 0);
    check("R1 busy at reset", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", busy, 0);

    // Directed corner cases
    runSeq(0, 0, 0, 32'h0, 0);            // R3 immediate pass
    runSeq(99, 0, 0, 32'h0, 0);           // R4 met on 100th sample
    runSeq(100, 0, 0, 32'h0, 0);          // R4 done timeout
    runSeq(5, 99, 0, 32'h0, 0);           // R8 fresh budget
    runSeq(50, 100, 0, 32'h0, 0);         // R5 idle timeout
    runSeq(60, 70, 100, 32'h0, 0);        // R6 drain timeout
    runSeq(60, 70, 99, 32'h0, 0);         // R6 last sample
    runSeq(1, 2, 3, 32'h8000_0000, 0);    // R7 error
    runSeq(4, 4, 4, 32'h0, 1);            // R10 start while busy

    // Constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 30; i++) begin
      int d1, d2, d3;
      logic [31:0] e;
      d1 = ($urandom() % 8 == 0) ? 99 + $urandom() % 3 : $urandom() % 20;
      d2 = ($urandom() % 8 == 0) ? 99 + $urandom() % 3 : $urandom() % 20;
      d3 = ($urandom() % 8 == 0) ? 99 + $urandom() % 3 : $urandom() % 20;
      e = ($urandom() % 3 == 0) ? (32'h1 << ($urandom() % 32)) : 32'h0;
      runSeq(d1, d2, d3, e, ($urandom() % 4 == 0));
    end
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule